// File: doc/BRIEF.md
# Two-Thread Decode Group Former

This block sits between two per-thread instruction queues and a shared four-op decode path. Each queue shows its oldest four entries to the block. Every entry is already classed as a one-op, two-op or microcoded instruction. Each cycle the block picks one thread. It packs that thread's oldest entries into the op slots in program order, and it reports how many entries the queue must drop at the next clock edge.

Thread choice flips every cycle while both threads are awake. A sleeping thread is left out, so the awake thread receives every cycle. A microcoded entry carries a total op count. It drains four ops per cycle of its thread and stays at the queue head until its last ops leave. Outputs are combinational from the presented window and a small amount of state: the arbitration pointer and one remaining-op counter per thread.

Top module: `grp_form_top`

## Requirements
- R1: While both threads are awake, on consecutive cycles, the served thread tag changes on every cycle.
- R2: While exactly one thread is asleep, every cycle serves the awake thread.
- R3: While both threads are asleep, no op slot is valid and both pop counts are zero. On waking, the thread that was not served last is served first.
- R4: Class code 00 (and the spare code 11) is a one-op entry. Up to four such entries fill slots 0..3 in program order, and each slot carries its entry's payload.
- R5: Class code 01 is a two-op entry. It fills two adjacent slots with its payload. At most one two-op entry is packed per cycle, alongside at most two one-op entries. A second two-op entry waits for a later cycle.
- R6: Packing stops at the first entry that is invalid, that does not fit the remaining slots, or that is microcoded but not at the head.
- R7: Class code 10 is a microcoded entry. At the head it is issued alone, with up to four ops per cycle and its payload in every slot. It resumes on later cycles of its thread. Its pop count is 0 until the cycle that issues its last ops, when the pop count is 1.
- R8: A served thread with no valid head entry gets an idle cycle. The slot is not handed to the other thread, and alternation still advances.
- R9: Valid op slots are always contiguous from slot 0. The pop count of the thread that is not served is zero.
- R10: Synchronous reset clears the remaining-op counters and makes thread 0 the first thread served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| sleep_i | input | 2 | Per-thread sleep, bit t for thread t |
| head_vld_i | input | 2x4 | Per-thread valid bits of the four oldest queue entries |
| head_cls_i | input | 2x4x2 | Per-entry class code |
| head_pay_i | input | 2x4x8 | Per-entry payload |
| head_ucnt_i | input | 2x6 | Total op count of the head entry when it is microcoded |
| op_vld_o | output | 4 | Op slot valid bits |
| op_pay_o | output | 4x8 | Payload of each op slot |
| op_tid_o | output | 1 | Thread tag of the current cycle |
| pop_cnt_o | output | 2x3 | Per-thread count of entries completed this cycle |

## Verification
The assertions check every cycle for the properties that hold at all times: the thread tag flips under dual wake, the awake thread is routed when the other sleeps, nothing issues under full sleep, and the valid slots stay contiguous. They also check that no more than one two-op entry is popped, that microcode is never grouped, and that thread 0 is served right after reset. The slot contents cannot be checked that way, so the bench scenarios cover them: the exact stopping point of each packing pattern, the per-slot payload order, and the way a long microcoded entry interleaves with the other thread. The bench also covers which thread goes first after a sleep period, and the clearing of a half-drained microcode count by reset.

// File: rtl/grp_form_pkg.sv
package grp_form_pkg;

   typedef enum logic [1:0] {
      CLS_SINGLE = 2'b00,
      CLS_DOUBLE = 2'b01,
      CLS_MICRO  = 2'b10,
      CLS_SPARE  = 2'b11
   } op_cls_e;

endpackage

// File: rtl/grp_form_arb.sv
module grp_form_arb (
   input  logic       clk_i,
   input  logic       rst_i,
   input  logic [1:0] sleep_i,
   output logic       grant_o,
   output logic       tid_o
);

   logic       nxt_q;
   logic [1:0] awake;

   always_comb begin
      awake   = ~sleep_i;
      grant_o = |awake;
      tid_o   = (&awake) ? nxt_q : awake[1];
   end

   // the pointer names the thread not served last; it holds while nothing is served
   always_ff @(posedge clk_i) begin
      if (rst_i)
         nxt_q <= 1'b0;
      else if (grant_o)
         nxt_q <= ~tid_o;
   end

endmodule

// File: rtl/grp_form_packer.sv
module grp_form_packer
   import grp_form_pkg::*;
#(
   parameter int OPS_W = 4,
   parameter int PW    = 8,
   parameter int CW    = 6,
   localparam int PCW  = $clog2(OPS_W + 1)
) (
   input  logic [OPS_W-1:0]         vld_i,
   input  logic [OPS_W-1:0][1:0]    cls_i,
   input  logic [OPS_W-1:0][PW-1:0] pay_i,
   input  logic [CW-1:0]            ucnt_i,
   input  logic [CW-1:0]            rem_q_i,
   output logic [OPS_W-1:0]         ovld_o,
   output logic [OPS_W-1:0][PW-1:0] opay_o,
   output logic [PCW-1:0]           pop_o,
   output logic [CW-1:0]            rem_d_o
);

   logic [CW-1:0] rem;
   logic          micro_mode;
   logic          dbl_seen;
   logic          stop;
   int            used;

   always_comb begin
      ovld_o   = '0;
      opay_o   = '0;
      pop_o    = '0;
      rem_d_o  = rem_q_i;
      used     = 0;
      dbl_seen = 1'b0;
      stop     = 1'b0;
      rem        = (rem_q_i != '0) ? rem_q_i : ucnt_i;
      micro_mode = (rem_q_i != '0) || (cls_i[0] == CLS_MICRO);

      if (micro_mode) begin
         if (vld_i[0]) begin
            for (int s = 0; s < OPS_W; s++) begin
               if (CW'(s) < rem) begin
                  ovld_o[s] = 1'b1;
                  opay_o[s] = pay_i[0];
               end
            end
            if (rem <= CW'(OPS_W)) begin
               pop_o   = PCW'(1);
               rem_d_o = '0;
            end else begin
               rem_d_o = rem - CW'(OPS_W);
            end
         end
      end else begin
         for (int i = 0; i < OPS_W; i++) begin
            if (!stop) begin
               if (!vld_i[i]) begin
                  stop = 1'b1;
               end else if (cls_i[i] == CLS_MICRO) begin
                  stop = 1'b1;
               end else if (cls_i[i] == CLS_DOUBLE) begin
                  if (dbl_seen || (used + 2 > OPS_W)) begin
                     stop = 1'b1;
                  end else begin
                     ovld_o[used]     = 1'b1;
                     opay_o[used]     = pay_i[i];
                     ovld_o[used + 1] = 1'b1;
                     opay_o[used + 1] = pay_i[i];
                     used             = used + 2;
                     dbl_seen         = 1'b1;
                     pop_o            = pop_o + PCW'(1);
                  end
               end else begin
                  if (used + 1 > OPS_W) begin
                     stop = 1'b1;
                  end else begin
                     ovld_o[used] = 1'b1;
                     opay_o[used] = pay_i[i];
                     used         = used + 1;
                     pop_o        = pop_o + PCW'(1);
                  end
               end
            end
         end
      end
   end

endmodule

// File: rtl/grp_form_top.sv
module grp_form_top #(
   parameter int OPS_W = 4,
   parameter int PW    = 8,
   parameter int CW    = 6,
   localparam int PCW  = $clog2(OPS_W + 1)
) (
   input  logic                              clk_i,
   input  logic                              rst_i,
   input  logic [1:0]                        sleep_i,
   input  logic [1:0][OPS_W-1:0]             head_vld_i,
   input  logic [1:0][OPS_W-1:0][1:0]        head_cls_i,
   input  logic [1:0][OPS_W-1:0][PW-1:0]     head_pay_i,
   input  logic [1:0][CW-1:0]                head_ucnt_i,
   output logic [OPS_W-1:0]                  op_vld_o,
   output logic [OPS_W-1:0][PW-1:0]          op_pay_o,
   output logic                              op_tid_o,
   output logic [1:0][PCW-1:0]               pop_cnt_o
);

   if (OPS_W < 2) begin : g_bad_w
      $error("grp_form_top: OPS_W must be at least 2");
   end
   if (CW <= $clog2(OPS_W)) begin : g_bad_cw
      $error("grp_form_top: CW too narrow for OPS_W");
   end
   if (PW < 1) begin : g_bad_pw
      $error("grp_form_top: PW must be positive");
   end

   logic                          grant;
   logic                          tid;
   logic [1:0][OPS_W-1:0]         pk_vld;
   logic [1:0][OPS_W-1:0][PW-1:0] pk_pay;
   logic [1:0][PCW-1:0]           pk_pop;
   logic [1:0][CW-1:0]            rem_q;
   logic [1:0][CW-1:0]            rem_d;

   grp_form_arb u_arb (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .sleep_i (sleep_i),
      .grant_o (grant),
      .tid_o   (tid)
   );

   for (genvar t = 0; t < 2; t++) begin : g_thr
      grp_form_packer #(.OPS_W(OPS_W), .PW(PW), .CW(CW)) u_pack (
         .vld_i   (head_vld_i[t]),
         .cls_i   (head_cls_i[t]),
         .pay_i   (head_pay_i[t]),
         .ucnt_i  (head_ucnt_i[t]),
         .rem_q_i (rem_q[t]),
         .ovld_o  (pk_vld[t]),
         .opay_o  (pk_pay[t]),
         .pop_o   (pk_pop[t]),
         .rem_d_o (rem_d[t])
      );

      always_ff @(posedge clk_i) begin
         if (rst_i)
            rem_q[t] <= '0;
         else if (grant && (tid == t[0]))
            rem_q[t] <= rem_d[t];
      end

      assign pop_cnt_o[t] = (grant && (tid == t[0])) ? pk_pop[t] : '0;
   end

   assign op_vld_o = grant ? pk_vld[tid] : '0;
   assign op_pay_o = grant ? pk_pay[tid] : '0;
   assign op_tid_o = tid;

endmodule

// File: rtl/grp_form_chk.sv
module grp_form_chk #(
   parameter int OPS_W = 4,
   parameter int PW    = 8,
   parameter int CW    = 6,
   localparam int PCW  = $clog2(OPS_W + 1)
) (
   input logic                          clk_i,
   input logic                          rst_i,
   input logic [1:0]                    sleep_i,
   input logic [1:0][OPS_W-1:0][1:0]    head_cls_i,
   input logic [OPS_W-1:0]              op_vld_o,
   input logic                          op_tid_o,
   input logic [1:0][PCW-1:0]           pop_cnt_o
);

   int   n_dbl;
   logic head_micro;

   always_comb begin
      n_dbl = 0;
      for (int i = 0; i < OPS_W; i++) begin
         if ((i < int'(pop_cnt_o[op_tid_o])) && (head_cls_i[op_tid_o][i] == 2'b01))
            n_dbl = n_dbl + 1;
      end
      head_micro = (head_cls_i[op_tid_o][0] == 2'b10);
   end

   // R1
   alt_flip_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (sleep_i == 2'b00 && $past(sleep_i) == 2'b00 && !$past(rst_i))
         |-> (op_tid_o != $past(op_tid_o)));

   // R2
   awake_route_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (sleep_i[0] != sleep_i[1]) |-> (op_tid_o == sleep_i[0]));

   // R3
   all_asleep_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (&sleep_i) |-> (op_vld_o == '0 && pop_cnt_o == '0));

   // R9
   contig_slot_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      ((op_vld_o & (op_vld_o + 1'b1)) == '0));

   // R9
   idle_pop_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (pop_cnt_o[~op_tid_o] == '0));

   // R5
   one_double_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (n_dbl <= 1));

   // R7
   micro_alone_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (head_micro && op_vld_o != '0) |-> (pop_cnt_o[op_tid_o] <= PCW'(1)));

   // R7
   micro_full_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (head_micro && op_vld_o != '0 && pop_cnt_o[op_tid_o] == '0) |-> (&op_vld_o));

   // R10
   reset_first_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      ($past(rst_i) && !sleep_i[0]) |-> (op_tid_o == 1'b0));

endmodule

bind grp_form_top grp_form_chk #(.OPS_W(OPS_W), .PW(PW), .CW(CW)) u_chk (
   .clk_i      (clk_i),
   .rst_i      (rst_i),
   .sleep_i    (sleep_i),
   .head_cls_i (head_cls_i),
   .op_vld_o   (op_vld_o),
   .op_tid_o   (op_tid_o),
   .pop_cnt_o  (pop_cnt_o)
);

// File: tb/grp_form_top_tb.sv
`timescale 1ns/1ps
module grp_form_top_tb;

   localparam int W  = 4;
   localparam int PW = 8;
   localparam int CW = 6;
   localparam logic [1:0] S = 2'b00;
   localparam logic [1:0] D = 2'b01;
   localparam logic [1:0] M = 2'b10;
   localparam logic [1:0] X = 2'b11;

   logic                    clk = 1'b0;
   logic                    rst;
   logic [1:0]              sleep;
   logic [1:0][W-1:0]       hvld;
   logic [1:0][W-1:0][1:0]  hcls;
   logic [1:0][W-1:0][PW-1:0] hpay;
   logic [1:0][CW-1:0]      hucnt;
   logic [W-1:0]            op_vld;
   logic [W-1:0][PW-1:0]    op_pay;
   logic                    op_tid;
   logic [1:0][2:0]         pop_cnt;

   int n_chk  = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   grp_form_top #(.OPS_W(W), .PW(PW), .CW(CW)) u_dut (
      .clk_i       (clk),
      .rst_i       (rst),
      .sleep_i     (sleep),
      .head_vld_i  (hvld),
      .head_cls_i  (hcls),
      .head_pay_i  (hpay),
      .head_ucnt_i (hucnt),
      .op_vld_o    (op_vld),
      .op_pay_o    (op_pay),
      .op_tid_o    (op_tid),
      .pop_cnt_o   (pop_cnt)
   );

   task automatic cmp(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic load(int t, logic [3:0] v, logic [1:0] c0, logic [1:0] c1,
                       logic [1:0] c2, logic [1:0] c3, int uc);
      hvld[t]    = v;
      hcls[t][0] = c0;
      hcls[t][1] = c1;
      hcls[t][2] = c2;
      hcls[t][3] = c3;
      hucnt[t]   = CW'(uc);
   endtask

   // sample one ns after the inputs settle; etid < 0 skips the tag check
   task automatic probe(string tag, int etid, logic [3:0] ev, int ep0, int ep1);
      #1;
      if (etid >= 0) cmp({tag, " tid"}, int'(op_tid), etid);
      cmp({tag, " vld"}, int'(op_vld), int'(ev));
      cmp({tag, " pop0"}, int'(pop_cnt[0]), ep0);
      cmp({tag, " pop1"}, int'(pop_cnt[1]), ep1);
   endtask

   task automatic pay(string tag, int slot, int exp);
      cmp({tag, " pay"}, int'(op_pay[slot]), exp);
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic t_reset_state();
      sleep = 2'b00;
      load(0, 4'b0000, S, S, S, S, 0);
      load(1, 4'b0000, S, S, S, S, 0);
      probe("R10 first thread after reset, R8 idle", 0, 4'b0000, 0, 0);
      tick();
   endtask

   task automatic t_alternate();
      load(0, 4'b1111, S, S, X, S, 0);
      load(1, 4'b1111, S, S, S, S, 0);
      probe("R1 R4 thread1 turn", 1, 4'b1111, 0, 4);
      for (int i = 0; i < 4; i++) pay("R4 slot order t1", i, 8'h20 + i);
      tick();
      probe("R1 R4 thread0 turn with spare code", 0, 4'b1111, 4, 0);
      for (int i = 0; i < 4; i++) pay("R4 slot order t0", i, 8'h10 + i);
      tick();
   endtask

   task automatic t_packing();
      sleep = 2'b10;
      load(1, 4'b1111, S, S, S, S, 0);
      load(0, 4'b1111, D, S, S, S, 0);
      probe("R5 double then two singles", 0, 4'b1111, 3, 0);
      pay("R5 slot0", 0, 8'h10); pay("R5 slot1", 1, 8'h10);
      pay("R5 slot2", 2, 8'h11); pay("R5 slot3", 3, 8'h12);
      tick();
      load(0, 4'b1111, S, D, S, S, 0);
      probe("R5 single double single", 0, 4'b1111, 3, 0);
      pay("R5 mid double", 2, 8'h11);
      tick();
      load(0, 4'b1111, D, D, S, S, 0);
      probe("R5 back to back doubles split", 0, 4'b0011, 1, 0);
      tick();
      load(0, 4'b1111, S, S, S, D, 0);
      probe("R6 double does not fit", 0, 4'b0111, 3, 0);
      tick();
      load(0, 4'b1111, S, M, S, S, 9);
      probe("R6 microcoded behind head", 0, 4'b0001, 1, 0);
      tick();
      load(0, 4'b1101, S, S, S, S, 0);
      probe("R6 invalid gap", 0, 4'b0001, 1, 0);
      tick();
   endtask

   task automatic t_micro_sleep();
      sleep = 2'b10;
      load(0, 4'b1111, M, S, S, S, 10);
      probe("R7 R2 micro pass 1", 0, 4'b1111, 0, 0);
      pay("R7 micro payload", 3, 8'h10);
      tick();
      probe("R7 R2 micro pass 2", 0, 4'b1111, 0, 0);
      tick();
      probe("R7 R2 micro last pass", 0, 4'b0011, 1, 0);
      tick();
   endtask

   task automatic t_micro_interleave();
      sleep = 2'b00;
      load(0, 4'b0001, M, S, S, S, 6);
      load(1, 4'b0011, S, S, S, S, 0);
      probe("R1 interleave t1 a", 1, 4'b0011, 0, 2);
      tick();
      probe("R7 interleave t0 a", 0, 4'b1111, 0, 0);
      tick();
      probe("R1 interleave t1 b", 1, 4'b0011, 0, 2);
      tick();
      probe("R7 interleave t0 resume", 0, 4'b0011, 1, 0);
      tick();
   endtask

   task automatic t_idle_slot();
      load(0, 4'b1111, S, S, S, S, 0);
      load(1, 4'b0000, S, S, S, S, 0);
      probe("R8 empty thread keeps slot", 1, 4'b0000, 0, 0);
      tick();
      probe("R8 alternation continues", 0, 4'b1111, 4, 0);
      tick();
   endtask

   task automatic t_sleep_wake();
      load(1, 4'b1111, S, S, S, S, 0);
      sleep = 2'b01;
      probe("R2 only thread1 awake", 1, 4'b1111, 0, 4);
      tick();
      sleep = 2'b11;
      probe("R3 both asleep", -1, 4'b0000, 0, 0);
      tick();
      sleep = 2'b00;
      probe("R3 wake serves thread0", 0, 4'b1111, 4, 0);
      tick();
      sleep = 2'b10;
      probe("R2 only thread0 awake", 0, 4'b1111, 4, 0);
      tick();
      sleep = 2'b11;
      probe("R3 both asleep again", -1, 4'b0000, 0, 0);
      tick();
      sleep = 2'b00;
      probe("R3 wake serves thread1", 1, 4'b1111, 0, 4);
      tick();
   endtask

   task automatic t_micro_exact();
      sleep = 2'b10;
      load(0, 4'b1111, M, S, S, S, 4);
      probe("R7 exact four", 0, 4'b1111, 1, 0);
      tick();
      probe("R7 next micro starts fresh", 0, 4'b1111, 1, 0);
      tick();
   endtask

   task automatic t_reset_mid_micro();
      sleep = 2'b10;
      load(0, 4'b1111, M, S, S, S, 6);
      probe("R7 before reset", 0, 4'b1111, 0, 0);
      rst = 1'b1;
      tick();
      rst = 1'b0;
      sleep = 2'b00;
      probe("R10 counter cleared, thread0 first", 0, 4'b1111, 0, 0);
      tick();
   endtask

   initial begin
      rst   = 1'b1;
      sleep = 2'b00;
      hvld  = '0;
      hcls  = '0;
      hucnt = '0;
      for (int t = 0; t < 2; t++)
         for (int i = 0; i < W; i++)
            hpay[t][i] = PW'(8'h10 * (t + 1) + i);
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      t_reset_state();
      t_alternate();
      t_packing();
      t_micro_sleep();
      t_micro_interleave();
      t_idle_slot();
      t_sleep_wake();
      t_micro_exact();
      t_reset_mid_micro();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule